// File: doc/BRIEF.md
# Byte-serial data-move instruction decoder

This block takes a stream of instruction bytes, one per accepted transfer, and recognises a small family of data-move encodings: the register/memory move opcodes 88h, 89h, 8Ah and 8Bh, and the byte-accumulator load A0h that carries an absolute address. An optional operand-size override byte (66h) may come first. After the opcode the decoder collects the ModR/M byte, an optional SIB byte and any displacement or address bytes that the addressing form requires. When the last byte of an instruction is accepted it presents a single decoded record for one cycle.

The record gives the effective operand width, the direction of the move, the register field, the r/m field, the mod field (the addressing form), the SIB byte when one was present, the displacement as a 32-bit value, and the total byte count of the instruction. A mode input chooses whether the default operand size is 16 or 32 bits. Any opcode outside the family produces a record flagged illegal, and the next byte begins a fresh instruction. The decoder does not compute addresses and does not execute anything.

Top module: `movdec_top`

## Requirements
- R1: For the full-width opcodes 89h and 8Bh, the width is 16 bits in 16-bit mode (mode32 = 0) and 32 bits in 32-bit mode (mode32 = 1). A leading 66h byte swaps the two cases. out_width encodes 8, 16 and 32 bits as 0, 1 and 2.
- R2: The byte opcodes 88h, 8Ah and A0h always report width code 0 (8 bits), whether or not a 66h byte precedes them.
- R3: out_to_rm is 1 for 88h and 89h (register to r/m) and 0 for 8Ah, 8Bh and A0h.
- R4: The ModR/M byte is reported as out_mod = bits 7:6, out_reg = bits 5:3 and out_rm = bits 2:0.
- R5: With mod = 3, no SIB byte and no displacement byte follow. out_disp is 0 and the length is 2, plus 1 when a 66h byte was present.
- R6: With mod = 1, exactly one displacement byte follows. It is reported sign-extended to 32 bits.
- R7: With mod = 2, the displacement is 4 bytes in 32-bit mode and 2 bytes in 16-bit mode. The bytes arrive least significant first and are reported zero-extended.
- R8: With mod = 0, a 4-byte absolute address follows when r/m = 5 in 32-bit mode, and a 2-byte absolute address follows when r/m = 6 in 16-bit mode. Any other mod = 0 form carries no displacement.
- R9: In 32-bit mode, mod != 3 together with r/m = 4 means a SIB byte follows the ModR/M byte. out_sib_valid is then 1, out_sib carries that byte and the SIB byte counts toward the length. In 16-bit mode no SIB byte is ever expected.
- R10: A0h has no ModR/M byte. It reports reg 0, mod 0 and r/m 5 (32-bit mode) or 6 (16-bit mode), direction 0 and width 8. The absolute address that follows is 4 bytes in 32-bit mode and 2 bytes in 16-bit mode.
- R11: Any other opcode byte, including a second 66h, yields a record with out_illegal = 1. In that record all other fields are 0 and the length is 1 without a prefix or 2 with one. The following byte starts a new instruction.
- R12: out_valid is low after reset. It is high for exactly the one cycle that follows acceptance of an instruction's final byte, and out_len counts every byte of that instruction.
- R13: in_ready is always 1. A byte is consumed only when in_valid is 1, and cycles with in_valid = 0 leave decoding unaffected whatever in_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode32 | input | 1 | Default operand size: 0 = 16-bit, 1 = 32-bit |
| in_valid | input | 1 | Instruction byte present |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted (always 1) |
| out_valid | output | 1 | Decoded record present this cycle |
| out_illegal | output | 1 | Opcode not in the decoded family |
| out_width | output | 2 | Operand width code: 0 = 8, 1 = 16, 2 = 32 bits |
| out_to_rm | output | 1 | 1 = move from reg to r/m |
| out_reg | output | 3 | Register field |
| out_rm | output | 3 | r/m field |
| out_mod | output | 2 | Addressing form (mod field) |
| out_sib_valid | output | 1 | A SIB byte was part of the instruction |
| out_sib | output | 8 | SIB byte |
| out_disp | output | 32 | Displacement or absolute address |
| out_len | output | 4 | Instruction length in bytes |

## Verification
The bench builds the decoder with its default parameters: a 4-byte maximum displacement and a 4-bit length field. With these values the longest legal form is reachable, namely override byte, opcode, ModR/M, SIB and a 32-bit displacement, 8 bytes in all. So are the 2-byte displacement and direct-address forms of 16-bit mode. The same streams are sent both back to back and with idle cycles holding misleading data. This exercises length counting and resynchronisation after illegal opcodes across both default modes.

// File: rtl/movdec_pkg.sv
`timescale 1ns/1ps
// Shared types for the data-move decoder.
package movdec_pkg;
    typedef enum logic [1:0] {
        OPW_8  = 2'd0,
        OPW_16 = 2'd1,
        OPW_32 = 2'd2
    } opw_e;

    typedef enum logic [2:0] {
        ST_LEAD,   // expecting override byte or opcode
        ST_OPC,    // override seen, expecting opcode
        ST_MODRM,
        ST_SIB,
        ST_DISP
    } st_e;

    typedef struct packed {
        logic legal;
        logic byte_op;
        logic to_rm;
        logic has_modrm;
    } opc_info_t;
endpackage

// File: rtl/movdec_opclass.sv
`timescale 1ns/1ps
// Opcode classifier. Purely combinational.
// Assumes the byte on opc is an opcode position; it says nothing about
// prefixes, which the caller filters out first.
module movdec_opclass
    import movdec_pkg::*;
(
    input  logic [7:0] opc,
    output opc_info_t  info
);
    // Classify the family: 88h..8Bh use bit0 for width and bit1 for direction.
    always_comb begin
        info = '0;
        if (opc[7:2] == 6'b100010) begin
            info.legal     = 1'b1;
            info.byte_op   = ~opc[0];
            info.to_rm     = ~opc[1];
            info.has_modrm = 1'b1;
        end else if (opc == 8'hA0) begin
            info.legal     = 1'b1;
            info.byte_op   = 1'b1;
            info.to_rm     = 1'b0;
            info.has_modrm = 1'b0;
        end
    end
endmodule

// File: rtl/movdec_form.sv
`timescale 1ns/1ps
// Addressing-form calculator: from mod, r/m and the default mode it
// derives whether a SIB byte follows and how many displacement bytes follow.
// Assumes CNT_W can hold the value 4.
module movdec_form #(
    parameter int CNT_W = 3
) (
    input  logic             mode32,
    input  logic [1:0]       mod_f,
    input  logic [2:0]       rm_f,
    output logic             need_sib,
    output logic [CNT_W-1:0] disp_bytes
);
    // SIB exists only in 32-bit mode for memory forms with r/m = 4.
    always_comb need_sib = mode32 && (mod_f != 2'b11) && (rm_f == 3'd4);

    // Displacement byte count per mod value.
    always_comb begin
        unique case (mod_f)
            2'b11:   disp_bytes = '0;
            2'b01:   disp_bytes = CNT_W'(1);
            2'b10:   disp_bytes = mode32 ? CNT_W'(4) : CNT_W'(2);
            default: begin
                if (mode32 && rm_f == 3'd5)       disp_bytes = CNT_W'(4);
                else if (!mode32 && rm_f == 3'd6) disp_bytes = CNT_W'(2);
                else                              disp_bytes = '0;
            end
        endcase
    end
endmodule

// File: rtl/movdec_disp.sv
`timescale 1ns/1ps
// Little-endian displacement assembler. Each loaded byte is placed at
// byte lane idx. value shows the result including the byte on byte_in,
// sign-extended from 8 bits when sext is set.
// Assumes idx < DISP_W/8 whenever load is high.
module movdec_disp #(
    parameter int DISP_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [CNT_W-1:0]  idx,
    input  logic [7:0]        byte_in,
    input  logic              sext,
    output logic [DISP_W-1:0] value
);
    logic [DISP_W-1:0] acc_q;
    logic [DISP_W-1:0] merged;

    // Insert the incoming byte into its lane.
    always_comb merged = acc_q | ({{(DISP_W-8){1'b0}}, byte_in} << {idx, 3'b000});

    // Final value: single-byte forms are sign-extended.
    always_comb value = sext ? {{(DISP_W-8){byte_in[7]}}, byte_in} : merged;

    // Hold partial displacement between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (load)     acc_q <= merged;
    end
endmodule

// File: rtl/movdec_top.sv
`timescale 1ns/1ps
// Byte-serial decoder for the 88h/89h/8Ah/8Bh/A0h move family.
// Accepts one byte per cycle when in_valid is high (never stalls) and
// registers one record per instruction, visible the cycle after its last
// byte. Assumes mode32 is stable from the opcode byte to the last byte.
module movdec_top
    import movdec_pkg::*;
#(
    parameter int         DISP_BYTES = 4,
    parameter int         LEN_W      = 4,
    parameter logic [7:0] PREFIX     = 8'h66
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode32,
    input  logic                      in_valid,
    input  logic [7:0]                in_data,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic                      out_illegal,
    output logic [1:0]                out_width,
    output logic                      out_to_rm,
    output logic [2:0]                out_reg,
    output logic [2:0]                out_rm,
    output logic [1:0]                out_mod,
    output logic                      out_sib_valid,
    output logic [7:0]                out_sib,
    output logic [8*DISP_BYTES-1:0]   out_disp,
    output logic [LEN_W-1:0]          out_len
);
    localparam int DISP_W = 8 * DISP_BYTES;
    localparam int CNT_W  = $clog2(DISP_BYTES + 1);

    st_e              state_q;
    logic             pfx_q, m32_q, byte_q, to_rm_q, sibv_q;
    logic [2:0]       reg_q, rm_q;
    logic [1:0]       mod_q;
    logic [7:0]       sib_q;
    logic [CNT_W-1:0] dcnt_q, idx_q;
    logic [LEN_W-1:0] len_q;

    opc_info_t        info;
    logic             f_sib;
    logic [CNT_W-1:0] f_cnt;
    logic             opc_now, emit, emit_ill, last_disp;
    logic [DISP_W-1:0] disp_val;
    opw_e             rec_w;

    assign in_ready = 1'b1;

    movdec_opclass opc_i (
        .opc  (in_data),
        .info (info)
    );

    movdec_form #(.CNT_W(CNT_W)) form_i (
        .mode32     (m32_q),
        .mod_f      (in_data[7:6]),
        .rm_f       (in_data[2:0]),
        .need_sib   (f_sib),
        .disp_bytes (f_cnt)
    );

    movdec_disp #(.DISP_W(DISP_W), .CNT_W(CNT_W)) disp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (emit),
        .load    (in_valid && state_q == ST_DISP),
        .idx     (idx_q),
        .byte_in (in_data),
        .sext    (dcnt_q == CNT_W'(1)),
        .value   (disp_val)
    );

    // The current byte is an opcode when it follows a prefix or is not one.
    always_comb opc_now = (state_q == ST_OPC) || (state_q == ST_LEAD && in_data != PREFIX);

    always_comb last_disp = (idx_q == dcnt_q - CNT_W'(1));

    // Decide whether the byte accepted now finishes an instruction.
    always_comb begin
        emit     = 1'b0;
        emit_ill = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_LEAD, ST_OPC: begin
                    emit_ill = opc_now && !info.legal;
                    emit     = emit_ill;
                end
                ST_MODRM: emit = !f_sib && (f_cnt == '0);
                ST_SIB:   emit = (dcnt_q == '0);
                ST_DISP:  emit = last_disp;
                default:  emit = 1'b0;
            endcase
        end
    end

    // Effective width: byte opcodes fixed, others default mode XOR override.
    always_comb rec_w = byte_q ? OPW_8 : ((m32_q ^ pfx_q) ? OPW_32 : OPW_16);

    // Sequencer: walks prefix, opcode, ModR/M, SIB and displacement bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LEAD;
            pfx_q   <= 1'b0;
            m32_q   <= 1'b0;
            byte_q  <= 1'b0;
            to_rm_q <= 1'b0;
            sibv_q  <= 1'b0;
            reg_q   <= '0;
            rm_q    <= '0;
            mod_q   <= '0;
            sib_q   <= '0;
            dcnt_q  <= '0;
            idx_q   <= '0;
            len_q   <= '0;
        end else if (in_valid) begin
            if (emit) begin
                state_q <= ST_LEAD;
                pfx_q   <= 1'b0;
                sibv_q  <= 1'b0;
                idx_q   <= '0;
                len_q   <= '0;
            end else begin
                len_q <= len_q + LEN_W'(1);
                if (opc_now) begin
                    m32_q   <= mode32;
                    byte_q  <= info.byte_op;
                    to_rm_q <= info.to_rm;
                    if (info.has_modrm) begin
                        state_q <= ST_MODRM;
                    end else begin
                        reg_q   <= 3'd0;
                        mod_q   <= 2'b00;
                        rm_q    <= mode32 ? 3'd5 : 3'd6;
                        dcnt_q  <= mode32 ? CNT_W'(4) : CNT_W'(2);
                        idx_q   <= '0;
                        state_q <= ST_DISP;
                    end
                end else begin
                    unique case (state_q)
                        ST_LEAD: begin
                            pfx_q   <= 1'b1;
                            state_q <= ST_OPC;
                        end
                        ST_MODRM: begin
                            mod_q   <= in_data[7:6];
                            reg_q   <= in_data[5:3];
                            rm_q    <= in_data[2:0];
                            dcnt_q  <= f_cnt;
                            idx_q   <= '0;
                            state_q <= f_sib ? ST_SIB : ST_DISP;
                        end
                        ST_SIB: begin
                            sib_q   <= in_data;
                            sibv_q  <= 1'b1;
                            state_q <= ST_DISP;
                        end
                        ST_DISP: idx_q <= idx_q + CNT_W'(1);
                        default: state_q <= ST_LEAD;
                    endcase
                end
            end
        end
    end

    // Output record register, loaded once per finished instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_illegal   <= 1'b0;
            out_width     <= '0;
            out_to_rm     <= 1'b0;
            out_reg       <= '0;
            out_rm        <= '0;
            out_mod       <= '0;
            out_sib_valid <= 1'b0;
            out_sib       <= '0;
            out_disp      <= '0;
            out_len       <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_illegal   <= emit_ill;
                out_width     <= emit_ill ? 2'd0 : rec_w;
                out_to_rm     <= !emit_ill && to_rm_q;
                out_reg       <= emit_ill ? 3'd0 : (state_q == ST_MODRM ? in_data[5:3] : reg_q);
                out_rm        <= emit_ill ? 3'd0 : (state_q == ST_MODRM ? in_data[2:0] : rm_q);
                out_mod       <= emit_ill ? 2'd0 : (state_q == ST_MODRM ? in_data[7:6] : mod_q);
                out_sib_valid <= !emit_ill && (state_q == ST_SIB || sibv_q);
                out_sib       <= emit_ill ? 8'd0 : (state_q == ST_SIB ? in_data : (sibv_q ? sib_q : 8'd0));
                out_disp      <= (state_q == ST_DISP) ? disp_val : '0;
                out_len       <= len_q + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/movdec_chk.sv
`timescale 1ns/1ps
// Property checker for movdec_top, attached by bind below.
// Relates the registered record fields to each other.
module movdec_chk #(
    parameter int DISP_W = 32,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [1:0]        out_width,
    input logic [1:0]        out_mod,
    input logic [2:0]        out_rm,
    input logic              out_sib_valid,
    input logic [DISP_W-1:0] out_disp,
    input logic [LEN_W-1:0]  out_len
);
    // R1: width code is one of the three defined values
    p_width_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_width != 2'b11);

    // R5: register form carries neither SIB nor displacement
    p_reg_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal && out_mod == 2'b11)
            |-> (!out_sib_valid && out_disp == '0 && out_len <= LEN_W'(3)));

    // R6: one-byte displacement appears sign-extended
    p_disp8_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal && out_mod == 2'b01)
            |-> out_disp == {{(DISP_W-8){out_disp[7]}}, out_disp[7:0]});

    // R9: a SIB byte only accompanies memory forms with r/m = 4
    p_sib_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sib_valid) |-> (out_mod != 2'b11 && out_rm == 3'd4));

    // R11: illegal records are short and otherwise empty
    p_illegal_rec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal)
            |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(2) && out_width == 2'd0
                 && out_disp == '0 && !out_sib_valid));

    // R12: legal instruction lengths stay within 2..8 bytes
    p_len_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal) |-> (out_len >= LEN_W'(2) && out_len <= LEN_W'(8)));
endmodule

bind movdec_top movdec_chk #(.DISP_W(DISP_W), .LEN_W(LEN_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_valid     (out_valid),
    .out_illegal   (out_illegal),
    .out_width     (out_width),
    .out_mod       (out_mod),
    .out_rm        (out_rm),
    .out_sib_valid (out_sib_valid),
    .out_disp      (out_disp),
    .out_len       (out_len)
);

// File: tb/movdec_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected records, the monitor pops
// and compares them on every out_valid.
module movdec_top_tb_top;
    typedef struct packed {
        logic        ill;
        logic [1:0]  w;
        logic        to_rm;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic [1:0]  md;
        logic        sv;
        logic [7:0]  sib;
        logic [31:0] disp;
        logic [3:0]  len;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode32 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, out_valid, out_illegal, out_to_rm, out_sib_valid;
    logic [1:0]  out_width, out_mod;
    logic [2:0]  out_reg, out_rm;
    logic [7:0]  out_sib;
    logic [31:0] out_disp;
    logic [3:0]  out_len;

    int   checks = 0;
    int   bad = 0;
    bit   gap_en = 1'b0;
    bit   finished = 1'b0;
    rec_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    movdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode32(mode32), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_width(out_width), .out_to_rm(out_to_rm),
        .out_reg(out_reg), .out_rm(out_rm), .out_mod(out_mod),
        .out_sib_valid(out_sib_valid), .out_sib(out_sib), .out_disp(out_disp),
        .out_len(out_len)
    );

    function automatic rec_t ok(input logic [1:0] w, input logic to_rm,
                                input logic [2:0] rg, input logic [2:0] rm,
                                input logic [1:0] md, input logic sv,
                                input logic [7:0] sib, input logic [31:0] disp,
                                input logic [3:0] len);
        return '{ill:1'b0, w:w, to_rm:to_rm, rg:rg, rm:rm, md:md, sv:sv,
                 sib:sib, disp:disp, len:len};
    endfunction

    function automatic rec_t ill(input logic [3:0] len);
        rec_t r = '0;
        r.ill = 1'b1;
        r.len = len;
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one byte for one cycle; optionally follow with an idle cycle
    // carrying a misleading value (R13).
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (gap_en) begin
            in_data = 8'h8B;
            @(posedge clk); #1;
        end
    endtask

    // Driver: queue the expected record, send n bytes (first byte in the
    // most significant used position), then check the record timing (R12).
    task automatic send(input string tag, input logic [63:0] seq, input int n, input rec_t e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 0; i < n; i++) begin
            logic saved_gap;
            saved_gap = gap_en;
            if (i == n - 1) gap_en = 1'b0;
            put(seq[8*(n-1-i) +: 8]);
            gap_en = saved_gap;
        end
        check({"R12 timing ", tag}, {63'd0, out_valid}, 64'd1);
    endtask

    // Monitor: compare each produced record with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            rec_t act;
            act = '{ill:out_illegal, w:out_width, to_rm:out_to_rm, rg:out_reg,
                    rm:out_rm, md:out_mod, sv:out_sib_valid, sib:out_sib,
                    disp:out_disp, len:out_len};
            if (exp_q.size() == 0) begin
                checks++;
                bad++;
                $display("FAIL R12: unexpected record actual %h expected none", act);
            end else begin
                rec_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 64'(act), 64'(e));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R13 in_ready", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // 16-bit default mode
        mode32 = 1'b0;
        send("R1 m16 8B C2",      64'h8BC2,     2, ok(2'd1,0,3'd0,3'd2,2'd3,0,8'h00,32'h0,4'd2));
        send("R1 m16 66 8B C2",   64'h668BC2,   3, ok(2'd2,0,3'd0,3'd2,2'd3,0,8'h00,32'h0,4'd3));
        send("R3 R4 m16 89 D8",   64'h89D8,     2, ok(2'd1,1,3'd3,3'd0,2'd3,0,8'h00,32'h0,4'd2));
        send("R2 m16 66 88 D8",   64'h6688D8,   3, ok(2'd0,1,3'd3,3'd0,2'd3,0,8'h00,32'h0,4'd3));
        send("R7 m16 mod2",       64'h8B873412, 4, ok(2'd1,0,3'd0,3'd7,2'd2,0,8'h00,32'h1234,4'd4));
        send("R8 m16 direct",     64'h8B063412, 4, ok(2'd1,0,3'd0,3'd6,2'd0,0,8'h00,32'h1234,4'd4));
        send("R8 m16 rm5 nodisp", 64'h8B05,     2, ok(2'd1,0,3'd0,3'd5,2'd0,0,8'h00,32'h0,4'd2));
        send("R9 m16 rm4 nosib",  64'h8B04,     2, ok(2'd1,0,3'd0,3'd4,2'd0,0,8'h00,32'h0,4'd2));
        send("R10 R2 m16 66 A0",  64'h66A03412, 4, ok(2'd0,0,3'd0,3'd6,2'd0,0,8'h00,32'h1234,4'd4));
        send("R6 m16 disp8 neg",  64'h8A4780,   3, ok(2'd0,0,3'd0,3'd7,2'd1,0,8'h00,32'hFFFFFF80,4'd3));

        // 32-bit default mode
        mode32 = 1'b1;
        send("R1 m32 8B C2",      64'h8BC2,     2, ok(2'd2,0,3'd0,3'd2,2'd3,0,8'h00,32'h0,4'd2));
        send("R1 m32 66 8B C2",   64'h668BC2,   3, ok(2'd1,0,3'd0,3'd2,2'd3,0,8'h00,32'h0,4'd3));
        send("R2 R5 m32 8A D9",   64'h8AD9,     2, ok(2'd0,0,3'd3,3'd1,2'd3,0,8'h00,32'h0,4'd2));
        send("R6 m32 disp8 pos",  64'h8B4710,   3, ok(2'd2,0,3'd0,3'd7,2'd1,0,8'h00,32'h10,4'd3));
        send("R7 m32 mod2",       64'h8B8778563412, 6, ok(2'd2,0,3'd0,3'd7,2'd2,0,8'h00,32'h12345678,4'd6));
        send("R8 m32 direct",     64'h668B0511223344, 7, ok(2'd1,0,3'd0,3'd5,2'd0,0,8'h00,32'h44332211,4'd7));
        send("R8 m32 rm6 nodisp", 64'h8B06,     2, ok(2'd2,0,3'd0,3'd6,2'd0,0,8'h00,32'h0,4'd2));
        send("R9 m32 sib",        64'h8B0488,   3, ok(2'd2,0,3'd0,3'd4,2'd0,1,8'h88,32'h0,4'd3));
        send("R9 m32 sib disp8",  64'h8B4424F8, 4, ok(2'd2,0,3'd0,3'd4,2'd1,1,8'h24,32'hFFFFFFF8,4'd4));
        send("R9 m32 longest",    64'h6689848878563412, 8, ok(2'd1,1,3'd0,3'd4,2'd2,1,8'h88,32'h12345678,4'd8));
        send("R10 m32 A0",        64'hA078563412, 5, ok(2'd0,0,3'd0,3'd5,2'd0,0,8'h00,32'h12345678,4'd5));

        // Illegal opcodes and resynchronisation
        send("R11 illegal 90",    64'h90,   1, ill(4'd1));
        send("R11 illegal 66 90", 64'h6690, 2, ill(4'd2));
        send("R11 illegal 66 66", 64'h6666, 2, ill(4'd2));
        send("R11 C3 first",      64'hC3,   1, ill(4'd1));
        send("R11 C3 second",     64'hC3,   1, ill(4'd1));
        send("R11 resync 8B C2",  64'h8BC2, 2, ok(2'd2,0,3'd0,3'd2,2'd3,0,8'h00,32'h0,4'd2));

        // Idle cycles between bytes carrying misleading data
        gap_en = 1'b1;
        send("R13 gaps mod2",     64'h8B8778563412, 6, ok(2'd2,0,3'd0,3'd7,2'd2,0,8'h00,32'h12345678,4'd6));
        send("R13 gaps 66 8B C2", 64'h668BC2, 3, ok(2'd1,0,3'd0,3'd2,2'd3,0,8'h00,32'h0,4'd3));
        gap_en = 1'b0;

        repeat (4) @(posedge clk);
        #1;
        check("R12 all records seen", 64'(exp_q.size()), 64'd0);
        check("R13 in_ready end", {63'd0, in_ready}, 64'd1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule